// File: doc/BRIEF.md
# Inbound Address Translation Window

This block is one inbound window of a bus bridge. It decides whether a memory address arriving from the external bus falls inside the window. When it does, the block rewrites the address into the local address space.

Software programs the window through a small register port that is selected by a two-bit code. There are three registers:

- **Size register.** Holds a high-order mask. The mask sets the window size in steps of 4KB, and every size is a power of two.
- **Local base.** Supplies the upper bits of the translated address.
- **Bus-side base (BAR).** Holds the window's position in bus space.

Sizing works by writing all ones to the bus-side base and reading it back. The bits that come back as 1 give the window size.

The hit flag and the translated address are combinational. They depend on the current register contents and the presented bus address. Register writes land on the next rising clock edge.

Top module: `inbound_xlat_window`

## Requirements
- R1: After reset, reading the size register returns 0xFFFFF001 (a 4KB window with the enable bit set). Reading the local base returns 0, and reading the bus-side base returns 0.
- R2: A write to the size register stores in bits 31:12 only the contiguous run of ones that starts at bit 31 of the written value. All mask bits below the first zero read 0. For example, writing 0xFFF0F000 reads back 0xFFF00001, and writing 0x7FFFF000 reads back 0x00000001.
- R3: In the size register, bit 0 always reads 1 and bits 11:1 always read 0, whatever value was written.
- R4: In the local base, only bits 31:12 take the written value. Bits 11:0 always read 0.
- R5: A write to the bus-side base keeps only the bits where the current mask is 1. On readback, the bus-side base shows 0 wherever the mask is 0. With mask 0xFF000000, writing 0xFFFFFFFF reads back 0xFF000000.
- R6: hit_o is 1 exactly when (bus_addr & M) == (bus_base & M). Here M is the mask with bits 11:0 taken as 0. With mask 0xFF000000 and base 0xFF000000, address 0xFF123456 hits and address 0xFE000000 misses.
- R7: local_addr_o equals (local_base & M) | (bus_addr & ~M).
- R8: The reg_sel_i encoding is 0 = size, 1 = local base, 2 = bus-side base. Code 3 reads 0, and writes to it change no register.
- R9: hit_o and local_addr_o follow bus_addr_i in the same cycle. A register write becomes visible on those outputs, and on reg_rdata_o, only after the next rising edge of clk_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| bus_addr_i | input | 32 | Incoming bus address |
| hit_o | output | 1 | Address falls inside the window |
| local_addr_o | output | 32 | Translated local address |

## Verification
A register write and a live translation can occur in the same cycle. For example, the local base or the mask can change while a bus address is being looked up. The bench provokes this by raising a write to the local base, the mask or the bus-side base in the same half-cycle that it presents a new bus address. It first checks that hit_o and local_addr_o still reflect the old register values before the edge. After the edge, it checks that they reflect the new values for the same address. Random traffic repeats this overlap many times, with both contiguous and non-contiguous mask writes.

// File: rtl/ixw_pkg.sv
package ixw_pkg;
  typedef enum logic [1:0] {
    SEL_SIZE  = 2'd0,
    SEL_LBASE = 2'd1,
    SEL_BAR   = 2'd2,
    SEL_NONE  = 2'd3
  } ixw_sel_e;
endpackage

// File: rtl/ixw_mask_reg.sv
module ixw_mask_reg #(
  parameter int unsigned MASK_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [MASK_W-1:0] wdata_i,
  output logic [MASK_W-1:0] mask_o
);
  logic [MASK_W-1:0] prefix;
  logic [MASK_W-1:0] mask_q;

  // keep only the leading run of ones
  assign prefix[MASK_W-1] = wdata_i[MASK_W-1];
  for (genvar i = MASK_W - 2; i >= 0; i--) begin : g_pfx
    assign prefix[i] = wdata_i[i] & prefix[i+1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_q <= '1;
    else if (wr_i) mask_q <= prefix;
  end

  assign mask_o = mask_q;

  logic [MASK_W-1:0] inv_mask;
  assign inv_mask = ~mask_q;

  AST_MASK_CONTIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_mask & (inv_mask + 1'b1)) == '0); // R2
  AST_MASK_SUBSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (mask_q & ~$past(wdata_i)) == '0); // R2
endmodule

// File: rtl/ixw_base_reg.sv
module ixw_base_reg #(
  parameter int unsigned MASK_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [MASK_W-1:0] wdata_i,
  input  logic [MASK_W-1:0] keep_i,
  output logic [MASK_W-1:0] q_o
);
  logic [MASK_W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= '0;
    else if (wr_i) q <= wdata_i & keep_i;
  end

  assign q_o = q;

  AST_BASE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (q & ~$past(keep_i)) == '0); // R5
endmodule

// File: rtl/ixw_match.sv
module ixw_match #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned GRAN_LG2 = 12,
  localparam int unsigned MASK_W  = ADDR_W - GRAN_LG2
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic [MASK_W-1:0] bar_i,
  input  logic [MASK_W-1:0] lbase_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] local_addr_o
);
  logic [MASK_W-1:0] hi;
  assign hi    = addr_i[ADDR_W-1:GRAN_LG2];
  assign hit_o = ((hi ^ bar_i) & mask_i) == '0;
  assign local_addr_o = {(lbase_i & mask_i) | (hi & ~mask_i), addr_i[GRAN_LG2-1:0]};
endmodule

// File: rtl/inbound_xlat_window.sv
module inbound_xlat_window
  import ixw_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned GRAN_LG2 = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [ADDR_W-1:0] reg_wdata_i,
  output logic [ADDR_W-1:0] reg_rdata_o,
  input  logic [ADDR_W-1:0] bus_addr_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] local_addr_o
);
  localparam int unsigned MASK_W = ADDR_W - GRAN_LG2;

  ixw_sel_e          sel;
  logic [MASK_W-1:0] wdata_hi;
  logic [MASK_W-1:0] mask;
  logic [MASK_W-1:0] lbase;
  logic [MASK_W-1:0] bar;
  logic              unused_wlow;

  assign sel         = ixw_sel_e'(reg_sel_i);
  assign wdata_hi    = reg_wdata_i[ADDR_W-1:GRAN_LG2];
  assign unused_wlow = ^reg_wdata_i[GRAN_LG2-1:0];

  ixw_mask_reg #(.MASK_W(MASK_W)) u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (reg_we_i && sel == SEL_SIZE),
    .wdata_i(wdata_hi),
    .mask_o (mask)
  );

  ixw_base_reg #(.MASK_W(MASK_W)) u_lbase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (reg_we_i && sel == SEL_LBASE),
    .wdata_i(wdata_hi),
    .keep_i ({MASK_W{1'b1}}),
    .q_o    (lbase)
  );

  ixw_base_reg #(.MASK_W(MASK_W)) u_bar (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (reg_we_i && sel == SEL_BAR),
    .wdata_i(wdata_hi),
    .keep_i (mask),
    .q_o    (bar)
  );

  ixw_match #(.ADDR_W(ADDR_W), .GRAN_LG2(GRAN_LG2)) u_match (
    .addr_i      (bus_addr_i),
    .mask_i      (mask),
    .bar_i       (bar),
    .lbase_i     (lbase),
    .hit_o       (hit_o),
    .local_addr_o(local_addr_o)
  );

  always_comb begin
    unique case (sel)
      SEL_SIZE:  reg_rdata_o = {mask, {(GRAN_LG2-1){1'b0}}, 1'b1};
      SEL_LBASE: reg_rdata_o = {lbase, {GRAN_LG2{1'b0}}};
      SEL_BAR:   reg_rdata_o = {bar & mask, {GRAN_LG2{1'b0}}};
      default:   reg_rdata_o = '0;
    endcase
  end

  logic [ADDR_W-1:0] full_mask;
  assign full_mask = {mask, {GRAN_LG2{1'b0}}};

  AST_SIZE_FIXED_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_sel_i == 2'd0 |-> reg_rdata_o[GRAN_LG2-1:0] == GRAN_LG2'(1)); // R3
  AST_LBASE_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_sel_i == 2'd1 |-> reg_rdata_o[GRAN_LG2-1:0] == '0); // R4
  AST_BAR_OUTSIDE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_sel_i == 2'd2 |-> (reg_rdata_o & ~full_mask) == '0); // R5
  AST_NONE_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_sel_i == 2'd3 |-> reg_rdata_o == '0); // R8
  AST_LOW_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((local_addr_o ^ bus_addr_i) & ~full_mask) == '0); // R7
  AST_LBASE_WRITE_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_sel_i == 2'd1) |=> lbase == $past(wdata_hi)); // R9
  AST_NONE_WRITE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_sel_i == 2'd3) |=> $stable(mask) && $stable(lbase) && $stable(bar)); // R8
endmodule

// File: tb/inbound_xlat_window_bench.sv
module inbound_xlat_window_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  sel = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] baddr = '0;
  logic        hit;
  logic [31:0] laddr;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [19:0] m_mask = '1, m_lbase = '0, m_bar = '0;

  always #2 clk = ~clk;

  inbound_xlat_window u_inbound_xlat_window (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_sel_i(sel),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .bus_addr_i(baddr),
    .hit_o(hit), .local_addr_o(laddr)
  );

  function automatic logic [19:0] pfx(input logic [19:0] w);
    logic [19:0] r = '0;
    for (int i = 19; i >= 0; i--) begin
      if (!w[i]) break;
      r[i] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [1:0] s);
    case (s)
      2'd0: return {m_mask, 11'b0, 1'b1};
      2'd1: return {m_lbase, 12'b0};
      2'd2: return {m_bar & m_mask, 12'b0};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] exp_la(input logic [31:0] a);
    logic [31:0] fm = {m_mask, 12'b0};
    return ({m_lbase, 12'b0} & fm) | (a & ~fm);
  endfunction

  function automatic logic exp_hit(input logic [31:0] a);
    return ((a[31:12] ^ m_bar) & m_mask) == 20'h0;
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic model_wr(input logic [1:0] s, input logic [31:0] d);
    case (s)
      2'd0: m_mask = pfx(d[31:12]);
      2'd1: m_lbase = d[31:12];
      2'd2: m_bar = d[31:12] & m_mask;
      default: ;
    endcase
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; sel = s; wdata = d;
    @(posedge clk);
    #1 we = 1'b0;
    model_wr(s, d);
  endtask

  task automatic rd(input string r, input logic [1:0] s);
    sel = s;
    #1 chk(r, rdata, exp_rd(s));
  endtask

  task automatic look(input string r, input logic [31:0] a);
    baddr = a;
    #1;
    chk({r, " hit"}, {31'b0, hit}, {31'b0, exp_hit(a)});
    chk({r, " laddr"}, laddr, exp_la(a));
  endtask

  // write and lookup in the same cycle: old values before edge, new after
  task automatic overlap(input logic [1:0] s, input logic [31:0] d, input logic [31:0] a);
    @(negedge clk);
    we = 1'b1; sel = s; wdata = d; baddr = a;
    #1;
    chk("R9 pre-edge hit", {31'b0, hit}, {31'b0, exp_hit(a)});
    chk("R9 pre-edge laddr", laddr, exp_la(a));
    @(posedge clk);
    #1 we = 1'b0;
    model_wr(s, d);
    chk("R9 post-edge hit", {31'b0, hit}, {31'b0, exp_hit(a)});
    chk("R9 post-edge laddr", laddr, exp_la(a));
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'h5eed_1234);
    #10 rst_n = 1'b1;
    #1;
    rd("R1 size reset", 2'd0);
    chk("R1 size value", rdata, 32'hFFFF_F001);
    rd("R1 lbase reset", 2'd1);
    rd("R1 bar reset", 2'd2);
    look("R6 reset lookup", 32'h0000_0ABC);

    wr(2'd0, 32'hFFF0_F123);
    rd("R2 noncontig mask", 2'd0);
    chk("R2 noncontig value", rdata, 32'hFFF0_0001);
    wr(2'd0, 32'h7FFF_FFFF);
    rd("R2 top zero mask", 2'd0);
    chk("R3 fixed bits", rdata, 32'h0000_0001);

    wr(2'd0, 32'hFF00_0000);
    rd("R3 16MB size", 2'd0);
    chk("R3 16MB value", rdata, 32'hFF00_0001);
    wr(2'd2, 32'hFFFF_FFFF);
    rd("R5 sizing readback", 2'd2);
    chk("R5 sizing value", rdata, 32'hFF00_0000);
    wr(2'd1, 32'h1234_5FFF);
    rd("R4 lbase", 2'd1);
    chk("R4 lbase value", rdata, 32'h1234_5000);
    look("R6 16MB hit", 32'hFF12_3456);
    chk("R7 16MB xlat", laddr, 32'h1212_3456);
    look("R6 16MB miss", 32'hFE00_0000);
    chk("R6 16MB miss flag", {31'b0, hit}, 32'h0);

    wr(2'd3, 32'hFFFF_FFFF);
    rd("R8 sel3 read", 2'd3);
    rd("R8 size kept", 2'd0);
    rd("R8 lbase kept", 2'd1);
    rd("R8 bar kept", 2'd2);

    overlap(2'd1, 32'hABCD_E000, 32'hFF77_7777);
    overlap(2'd0, 32'hFFFF_F000, 32'hFF00_0123);
    overlap(2'd2, 32'h0000_1000, 32'h0000_1FFF);

    for (int it = 0; it < 600; it++) begin
      int op = $urandom_range(0, 5);
      logic [31:0] d = $urandom;
      logic [1:0] s = 2'($urandom_range(0, 3));
      if (s == 2'd0 && $urandom_range(0, 1) == 1)
        d = 32'hFFFF_FFFF << $urandom_range(12, 32);
      case (op)
        0: begin wr(s, d); rd("R2/R4/R5/R8 rand read", s); end
        1: overlap(s, d, $urandom);
        2, 3: look("R6/R7 rand near", ({m_bar, 12'b0} & {m_mask, 12'b0}) |
                                      ($urandom & ~{m_mask, 12'b0}));
        default: look("R6/R7 rand any", $urandom);
      endcase
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule